// File: doc/BRIEF.md
# Latency Tolerance Report Generator

This block sits on the device side of a link and decides how much memory-access latency the device can currently tolerate from the platform. It watches a per-cycle traffic strobe and moves between three tolerance tiers: a tight "busy" tier while traffic flows, a looser "lingering" tier after a programmable quiet period, and a "dormant" tier after a second quiet period. The dormant tier's value depends on link status. A disconnected device reports that it has no requirement. A connected device in its low-power mode reports the firmware-programmed platform ceiling. A connected device that is awake keeps the lingering value.

Each chosen value is clamped to the firmware ceiling. It is then encoded as a 10-bit mantissa and a 3-bit scale and offered on a valid/ready message port. Repeats of the last accepted value are suppressed. A pending offer that has not been accepted is overwritten by newer choices. Software may override the tier value, but an override below the busy-tier floor lasts only a bounded number of cycles. The block also outputs the tolerance that the device itself must still honour. A tighter value takes effect at once, while a looser one waits until its message has been accepted.

Top module: `lat_tol_reporter`

## Requirements
- R1: A cycle with `activity` high puts the block in the busy tier on the next clock edge. The busy tier selects BUSY_NS (60000 ns by default).
- R2: After `tmo_linger` consecutive quiet edges, the busy tier moves to the lingering tier, which selects LINGER_NS (300000 ns by default). After a further `tmo_dormant` quiet edges, it moves to the dormant tier. Any activity returns the block to the busy tier.
- R3: In the dormant tier the selected value depends on link status. With `link_up` low, it is "no requirement": `msg_noreq` is 1 and mantissa and scale are 0. With `link_up` and `low_power` both high, it is `max_lat_ns`. With `link_up` high and `low_power` low, it is LINGER_NS.
- R4: No offered value other than "no requirement" decodes to more than `max_lat_ns`. Larger selections are replaced by `max_lat_ns`.
- R5: While `ovr_en` is high, `ovr_ns` replaces the tier value. An override below BUSY_NS is used for at most SUBFLOOR_CYC edges, after which BUSY_NS is selected until the override rises to at least BUSY_NS or is dropped.
- R6: Encoding: a scale of s means units of 2^(5*s) ns. The scale is the smallest one for which the mantissa fits in 10 bits, and the mantissa is the value divided by that unit, rounded down.
- R7: An offer is made only when the selected code differs from the last accepted code. After reset, the last accepted code counts as "no requirement".
- R8: An offer stays on `msg_valid` with unchanged fields until `msg_ready` is high, unless a newer selection replaces it.
- R9: A newer selection replaces a pending offer. If the newer selection equals the last accepted code, the pending offer is withdrawn and `msg_valid` falls.
- R10: `honour_ns` falls to a tighter selected value on the next edge. A looser value reaches `honour_ns` only on the edge at which its message is accepted. "No requirement" is shown as all ones.
- R11: During reset, `msg_valid` is 0 and `honour_ns` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| activity | input | 1 | Traffic seen this cycle |
| link_up | input | 1 | Device connected or associated |
| low_power | input | 1 | Connected device is in its low-power mode |
| max_lat_ns | input | NS_W | Firmware ceiling on any reported value, ns |
| tmo_linger | input | TMO_W | Quiet edges from busy to lingering tier |
| tmo_dormant | input | TMO_W | Quiet edges from lingering to dormant tier |
| ovr_en | input | 1 | Software override enable |
| ovr_ns | input | NS_W | Software override value, ns |
| msg_valid | output | 1 | Report offered |
| msg_ready | input | 1 | Report taken this cycle |
| msg_noreq | output | 1 | Report means "no requirement" |
| msg_mant | output | 10 | Report mantissa |
| msg_scale | output | 3 | Report scale |
| honour_ns | output | NS_W | Tolerance the device must still meet, ns |

## Verification
Directed sequences walk the tier ladder with the port held back, so that stable offers, replacements and withdrawals can each be told apart by the fields that stay on the port. Link and low-power combinations in the dormant tier separate the three dormant outcomes, and lowering the ceiling shows clamping in both the lingering and dormant tiers. Overrides at mantissa boundaries (1023 versus 1024) and across scales check the encoding, and a sub-floor override held past its limit shows the floor return. A long seeded random phase with bursty traffic, a stalling receiver and link flips checks every accepted report for repeats and ceiling violations, and checks `honour_ns` against the last accepted value.

// File: rtl/ltr_pkg.sv
// Shared types and helpers for the latency tolerance reporter.
// Assumes a 10-bit mantissa and a scale step of 5 bits (x32 per scale).
package ltr_pkg;

    localparam int LTR_MANT_W  = 10;
    localparam int LTR_SCALE_W = 3;
    localparam int LTR_STEP    = 5;

    typedef enum logic [1:0] {
        TIER_BUSY    = 2'd0,
        TIER_LINGER  = 2'd1,
        TIER_DORMANT = 2'd2
    } tier_e;

    typedef struct packed {
        logic                   noreq;
        logic [LTR_MANT_W-1:0]  mant;
        logic [LTR_SCALE_W-1:0] scale;
    } ltr_code_t;

    // Expand a code to nanoseconds; "no requirement" becomes all ones.
    function automatic logic [63:0] ltr_decode(ltr_code_t c);
        if (c.noreq) return '1;
        return 64'(c.mant) << (LTR_STEP * int'(c.scale));
    endfunction

endpackage

// File: rtl/ltr_tier_fsm.sv
// Tier tracker: busy on any activity, then lingering and dormant after
// two programmable runs of quiet cycles. A timeout of 0 acts like 1.
module ltr_tier_fsm
    import ltr_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             activity,
    input  logic [TMO_W-1:0] tmo_linger,
    input  logic [TMO_W-1:0] tmo_dormant,
    output tier_e            tier
);
    logic [TMO_W-1:0] quiet_cnt;
    logic [TMO_W-1:0] limit;
    logic [TMO_W:0]   cnt_inc;
    logic             expire;

    // Pick the timeout that applies to the current tier and test it.
    always_comb begin
        limit   = (tier == TIER_BUSY) ? tmo_linger : tmo_dormant;
        cnt_inc = {1'b0, quiet_cnt} + 1'b1;
        expire  = cnt_inc >= {1'b0, limit};
    end

    // Advance the tier on timeouts, fall back to busy on traffic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tier      <= TIER_BUSY;
            quiet_cnt <= '0;
        end else if (activity) begin
            tier      <= TIER_BUSY;
            quiet_cnt <= '0;
        end else if (tier != TIER_DORMANT) begin
            if (expire) begin
                tier      <= (tier == TIER_BUSY) ? TIER_LINGER : TIER_DORMANT;
                quiet_cnt <= '0;
            end else begin
                quiet_cnt <= cnt_inc[TMO_W-1:0];
            end
        end
    end

    assert_busy_on_traffic_R1: assert property (@(posedge clk) disable iff (!rst_n)
        activity |=> tier == TIER_BUSY);

    assert_no_tier_skip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tier == TIER_BUSY && !activity) |=> tier != TIER_DORMANT);

    assert_dormant_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tier == TIER_DORMANT && !activity) |=> tier == TIER_DORMANT);

endmodule

// File: rtl/ltr_value_sel.sv
// Value selector: maps tier, link status and software override to a
// tolerance in ns, enforces the sub-floor time limit and the ceiling.
module ltr_value_sel
    import ltr_pkg::*;
#(
    parameter int          NS_W         = 32,
    parameter int unsigned BUSY_NS      = 60000,
    parameter int unsigned LINGER_NS    = 300000,
    parameter int          SUBFLOOR_CYC = 4096
) (
    input  logic            clk,
    input  logic            rst_n,
    input  tier_e           tier,
    input  logic            link_up,
    input  logic            low_power,
    input  logic [NS_W-1:0] max_lat_ns,
    input  logic            ovr_en,
    input  logic [NS_W-1:0] ovr_ns,
    output logic            sel_noreq,
    output logic [NS_W-1:0] sel_ns
);
    localparam int SF_W = $clog2(SUBFLOOR_CYC + 1);
    localparam logic [NS_W-1:0] FLOOR = NS_W'(BUSY_NS);
    localparam logic [NS_W-1:0] LINGER = NS_W'(LINGER_NS);

    logic [SF_W-1:0] sub_cnt;
    logic            below_floor;
    logic            sub_expired;
    logic [NS_W-1:0] raw_ns;
    logic            raw_noreq;

    assign below_floor = ovr_en && (ovr_ns < FLOOR);
    assign sub_expired = sub_cnt == SF_W'(SUBFLOOR_CYC);

    // Count edges spent with a sub-floor override, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !below_floor) sub_cnt <= '0;
        else if (!sub_expired)      sub_cnt <= sub_cnt + 1'b1;
    end

    // Choose the tier value, apply override and floor, then the ceiling.
    always_comb begin
        raw_noreq = 1'b0;
        unique case (tier)
            TIER_BUSY:   raw_ns = FLOOR;
            TIER_LINGER: raw_ns = LINGER;
            default: begin
                if (!link_up) begin
                    raw_ns    = '0;
                    raw_noreq = 1'b1;
                end else if (low_power) begin
                    raw_ns = max_lat_ns;
                end else begin
                    raw_ns = LINGER;
                end
            end
        endcase
        if (ovr_en) begin
            raw_noreq = 1'b0;
            raw_ns    = (below_floor && sub_expired) ? FLOOR : ovr_ns;
        end
        sel_noreq = raw_noreq;
        sel_ns    = raw_noreq ? '0 : ((raw_ns > max_lat_ns) ? max_lat_ns : raw_ns);
    end

    assert_floor_returns_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_en && sub_expired) |-> (!sel_noreq && (sel_ns >= FLOOR || sel_ns == max_lat_ns)));

    assert_disconnected_noreq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tier == TIER_DORMANT && !link_up && !ovr_en) |-> sel_noreq);

endmodule

// File: rtl/ltr_encoder.sv
// Encoder: converts a value in ns to mantissa/scale, using the smallest
// scale whose mantissa fits and rounding down (always the tighter side).
module ltr_encoder
    import ltr_pkg::*;
#(
    parameter int NS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            noreq_in,
    input  logic [NS_W-1:0] ns_in,
    output ltr_code_t       code
);
    localparam int NSC = 1 << LTR_SCALE_W;

    logic [NSC-1:0]        fits;
    logic [LTR_MANT_W-1:0] mant_s [NSC];
    logic [LTR_SCALE_W-1:0] pick;
    logic                   found;

    for (genvar g = 0; g < NSC; g++) begin : g_scale
        localparam int SH = g * LTR_STEP;
        logic [NS_W-1:0] shifted;
        assign shifted   = ns_in >> SH;
        assign fits[g]   = (shifted >> LTR_MANT_W) == '0;
        assign mant_s[g] = shifted[LTR_MANT_W-1:0];
    end

    // Priority-select the lowest scale that fits; saturate if none does.
    always_comb begin
        pick  = '1;
        found = 1'b0;
        for (int i = NSC - 1; i >= 0; i--) begin
            if (fits[i]) begin
                pick  = LTR_SCALE_W'(i);
                found = 1'b1;
            end
        end
        code.noreq = noreq_in;
        code.scale = noreq_in ? '0 : pick;
        code.mant  = noreq_in ? '0 : (found ? mant_s[pick] : '1);
    end

    assert_encode_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !code.noreq |-> (ltr_decode(code) <= 64'(ns_in) &&
                         (code.scale == '0 || code.mant >= LTR_MANT_W'(32))));

endmodule

// File: rtl/ltr_msg_queue.sv
// Message slot: holds one pending report, drops repeats of the last
// accepted code, lets newer choices overwrite or withdraw the pending
// one, and tracks the tolerance the device must still honour.
module ltr_msg_queue
    import ltr_pkg::*;
#(
    parameter int NS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  ltr_code_t       cand,
    input  logic [NS_W-1:0] max_lat_ns,
    input  logic            msg_ready,
    output logic            msg_valid,
    output ltr_code_t       msg_code,
    output logic [NS_W-1:0] honour_ns
);
    localparam ltr_code_t NOREQ_CODE = '{noreq: 1'b1, mant: '0, scale: '0};

    ltr_code_t       last_code, nxt_last, nxt_pcode, tgt;
    logic            pend, nxt_pend, fire;
    logic [63:0]     base_ns, cand_ns;
    logic [NS_W-1:0] nxt_hon;

    assign fire      = pend && msg_ready;
    assign msg_valid = pend;

    // Saturate a decoded value into the output width.
    function automatic logic [NS_W-1:0] fit_ns(logic [63:0] v);
        return (v > 64'({NS_W{1'b1}})) ? '1 : v[NS_W-1:0];
    endfunction

    // Work out next pending slot, last accepted code and honoured value.
    always_comb begin
        nxt_last  = fire ? msg_code : last_code;
        nxt_pend  = pend && !fire;
        nxt_pcode = msg_code;
        tgt       = nxt_pend ? msg_code : nxt_last;
        if (cand != tgt) begin
            if (cand == nxt_last) begin
                nxt_pend = 1'b0;
            end else begin
                nxt_pend  = 1'b1;
                nxt_pcode = cand;
            end
        end
        base_ns = fire ? ltr_decode(msg_code) : 64'(honour_ns);
        cand_ns = ltr_decode(cand);
        nxt_hon = fit_ns((cand_ns < base_ns) ? cand_ns : base_ns);
    end

    // Register the slot state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            msg_code  <= NOREQ_CODE;
            last_code <= NOREQ_CODE;
            honour_ns <= '1;
        end else begin
            pend      <= nxt_pend;
            msg_code  <= nxt_pcode;
            last_code <= nxt_last;
            honour_ns <= nxt_hon;
        end
    end

    assert_hold_offer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready && cand == msg_code) |=> (msg_valid && $stable(msg_code)));

    assert_no_repeat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> msg_code != last_code);

    assert_under_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_code.noreq) |-> ltr_decode(msg_code) <= 64'(max_lat_ns));

    assert_honour_tight_R10: assert property (@(posedge clk) disable iff (!rst_n)
        64'(honour_ns) <= ltr_decode(last_code));

    assert_loosen_waits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && ltr_decode(cand) >= 64'(honour_ns)) |=> $stable(honour_ns));

endmodule

// File: rtl/lat_tol_reporter.sv
// Top: tier tracker -> value selector -> encoder -> message slot.
// Assumes inputs are synchronous to clk; one report in flight at a time.
module lat_tol_reporter
    import ltr_pkg::*;
#(
    parameter int          NS_W         = 32,
    parameter int          TMO_W        = 16,
    parameter int unsigned BUSY_NS      = 60000,
    parameter int unsigned LINGER_NS    = 300000,
    parameter int          SUBFLOOR_CYC = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             activity,
    input  logic             link_up,
    input  logic             low_power,
    input  logic [NS_W-1:0]  max_lat_ns,
    input  logic [TMO_W-1:0] tmo_linger,
    input  logic [TMO_W-1:0] tmo_dormant,
    input  logic             ovr_en,
    input  logic [NS_W-1:0]  ovr_ns,
    output logic             msg_valid,
    input  logic             msg_ready,
    output logic             msg_noreq,
    output logic [9:0]       msg_mant,
    output logic [2:0]       msg_scale,
    output logic [NS_W-1:0]  honour_ns
);
    tier_e           tier;
    logic            sel_noreq;
    logic [NS_W-1:0] sel_ns;
    ltr_code_t       cand, code_q;

    ltr_tier_fsm #(.TMO_W(TMO_W)) u_tier (
        .clk(clk), .rst_n(rst_n), .activity(activity),
        .tmo_linger(tmo_linger), .tmo_dormant(tmo_dormant), .tier(tier)
    );

    ltr_value_sel #(
        .NS_W(NS_W), .BUSY_NS(BUSY_NS), .LINGER_NS(LINGER_NS),
        .SUBFLOOR_CYC(SUBFLOOR_CYC)
    ) u_sel (
        .clk(clk), .rst_n(rst_n), .tier(tier), .link_up(link_up),
        .low_power(low_power), .max_lat_ns(max_lat_ns), .ovr_en(ovr_en),
        .ovr_ns(ovr_ns), .sel_noreq(sel_noreq), .sel_ns(sel_ns)
    );

    ltr_encoder #(.NS_W(NS_W)) u_enc (
        .clk(clk), .rst_n(rst_n), .noreq_in(sel_noreq), .ns_in(sel_ns), .code(cand)
    );

    ltr_msg_queue #(.NS_W(NS_W)) u_q (
        .clk(clk), .rst_n(rst_n), .cand(cand), .max_lat_ns(max_lat_ns),
        .msg_ready(msg_ready), .msg_valid(msg_valid), .msg_code(code_q),
        .honour_ns(honour_ns)
    );

    assign msg_noreq = code_q.noreq;
    assign msg_mant  = code_q.mant;
    assign msg_scale = code_q.scale;

endmodule

// File: tb/lat_tol_reporter_test.sv
module lat_tol_reporter_test;
    localparam int TL = 20, TD = 30, SF = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, activity = 1'b0, link_up = 1'b1, low_power = 1'b1;
    logic [31:0] max_lat_ns = 32'd1000000, ovr_ns = '0;
    logic [15:0] tmo_linger = 16'(TL), tmo_dormant = 16'(TD);
    logic        ovr_en = 1'b0, msg_ready = 1'b0;
    logic        msg_valid, msg_noreq;
    logic [9:0]  msg_mant;
    logic [2:0]  msg_scale;
    logic [31:0] honour_ns;

    int n_cmp = 0, n_bad = 0;
    bit done = 0, fire_rules = 0;
    logic [13:0] last_acc = {1'b1, 13'd0};

    always #10 clk = ~clk;

    lat_tol_reporter #(.SUBFLOOR_CYC(SF)) uut (
        .clk(clk), .rst_n(rst_n), .activity(activity), .link_up(link_up),
        .low_power(low_power), .max_lat_ns(max_lat_ns), .tmo_linger(tmo_linger),
        .tmo_dormant(tmo_dormant), .ovr_en(ovr_en), .ovr_ns(ovr_ns),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_noreq(msg_noreq),
        .msg_mant(msg_mant), .msg_scale(msg_scale), .honour_ns(honour_ns)
    );

    // Reference encoding from R6: {noreq, mant, scale}.
    function automatic logic [13:0] enc(longint unsigned ns);
        for (int s = 0; s < 8; s++)
            if ((ns >> (5 * s)) < 1024) return {1'b0, 10'(ns >> (5 * s)), 3'(s)};
        return {1'b0, 10'h3FF, 3'd7};
    endfunction

    function automatic longint unsigned dec(logic [13:0] c);
        if (c[13]) return 64'hFFFF_FFFF;
        return longint'(c[12:3]) << (5 * int'(c[2:0]));
    endfunction

    task automatic chk(bit ok, string req, longint unsigned act, longint unsigned exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [13:0] port_code();
        return {msg_noreq, msg_mant, msg_scale};
    endfunction

    // One clock: note an acceptance due at the coming edge, then advance.
    task automatic step();
        if (msg_valid && msg_ready) begin
            if (fire_rules) begin
                chk(port_code() != last_acc, "R7", port_code(), last_acc);
                chk(msg_noreq || dec(port_code()) <= max_lat_ns, "R4",
                    dec(port_code()), max_lat_ns);
            end
            last_acc = port_code();
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic pulse();
        activity = 1'b1; step(); activity = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        steps(3);
        chk(msg_valid == 1'b0, "R11 valid", msg_valid, 0);
        chk(honour_ns == 32'hFFFF_FFFF, "R11 honour", honour_ns, 32'hFFFF_FFFF);
        rst_n = 1'b1;
        steps(3);
        chk(msg_valid && port_code() == enc(60000), "R1 busy offer", port_code(), enc(60000));
        chk(honour_ns == 32'(dec(enc(60000))), "R10 tighten", honour_ns, dec(enc(60000)));
        steps(10);
        chk(msg_valid && port_code() == enc(60000), "R8 held", port_code(), enc(60000));
        msg_ready = 1'b1; step(); msg_ready = 1'b0;
        chk(!msg_valid, "R8 taken", msg_valid, 0);
        begin
            bit quiet = 1;
            for (int k = 0; k < 8; k++) begin
                pulse(); steps(4);
                if (msg_valid) quiet = 0;
            end
            chk(quiet, "R7 no repeat", !quiet, 0);
        end
        steps(TL + 5);
        chk(msg_valid && port_code() == enc(300000), "R2 linger", port_code(), enc(300000));
        chk(honour_ns == 32'(dec(enc(60000))), "R10 loosen waits", honour_ns, dec(enc(60000)));
        msg_ready = 1'b1; step(); msg_ready = 1'b0;
        chk(honour_ns == 32'(dec(enc(300000))), "R10 loosen on accept", honour_ns, dec(enc(300000)));
        steps(TD + 5);
        chk(msg_valid && port_code() == enc(1000000), "R2 dormant", port_code(), enc(1000000));
        pulse(); steps(2);
        chk(msg_valid && port_code() == enc(60000), "R9 replace", port_code(), enc(60000));
        chk(honour_ns == 32'(dec(enc(60000))), "R10 tighten pending", honour_ns, dec(enc(60000)));
        msg_ready = 1'b1; step(); msg_ready = 1'b0;
        steps(TL + 3);
        chk(msg_valid && port_code() == enc(300000), "R9 pre-withdraw", port_code(), enc(300000));
        pulse(); steps(2);
        chk(!msg_valid, "R9 withdraw", msg_valid, 0);
        // Dormant outcomes by link status.
        link_up = 1'b0; msg_ready = 1'b1;
        steps(TL + TD + 10);
        chk(last_acc == {1'b1, 13'd0}, "R3 disconnected", last_acc, {1'b1, 13'd0});
        link_up = 1'b1; low_power = 1'b0; steps(4);
        chk(last_acc == enc(300000), "R3 awake", last_acc, enc(300000));
        low_power = 1'b1; steps(4);
        chk(last_acc == enc(1000000), "R3 low power", last_acc, enc(1000000));
        max_lat_ns = 32'd100000; steps(4);
        chk(last_acc == enc(100000), "R4 dormant clamp", last_acc, enc(100000));
        pulse(); steps(TL + 4);
        chk(last_acc == enc(100000), "R4 linger clamp", last_acc, enc(100000));
        // Override and the sub-floor limit.
        max_lat_ns = 32'hFFFF_FFFF; ovr_en = 1'b1; ovr_ns = 32'd20000; steps(5);
        chk(last_acc == enc(20000), "R5 short sub-floor", last_acc, enc(20000));
        steps(SF + 20);
        chk(last_acc == enc(60000), "R5 floor returns", last_acc, enc(60000));
        ovr_ns = 32'd5000000; max_lat_ns = 32'd100000; steps(4);
        chk(last_acc == enc(100000), "R4 override clamp", last_acc, enc(100000));
        max_lat_ns = 32'hFFFF_FFFF;
        begin
            longint unsigned vals[5] = '{1000, 1023, 1024, 40000000, 123456789};
            foreach (vals[j]) begin
                ovr_ns = 32'(vals[j]); steps(4);
                chk(last_acc == enc(vals[j]), "R6 encode", last_acc, enc(vals[j]));
            end
        end
        chk(enc(1024) == {1'b0, 10'd32, 3'd1}, "R6 boundary", enc(1024), {1'b0, 10'd32, 3'd1});
        ovr_en = 1'b0; max_lat_ns = 32'd1000000; steps(4);
        // Seeded random traffic, stalls and link changes.
        fire_rules = 1;
        begin
            int unsigned seed = 32'd20240611;
            void'($urandom(seed));
            for (int c = 0; c < 4000; c++) begin
                activity  = ($urandom % 16) == 0;
                msg_ready = ($urandom % 3) != 0;
                if (($urandom % 200) == 0) link_up = ~link_up;
                if (($urandom % 200) == 0) low_power = ~low_power;
                step();
                chk(longint'(honour_ns) <= dec(last_acc), "R10 honour bound", honour_ns, dec(last_acc));
            end
        end
        activity = 1'b0; msg_ready = 1'b1;
        steps(TL + TD + 10);
        begin
            logic [13:0] exp_c;
            exp_c = !link_up ? {1'b1, 13'd0} : (low_power ? enc(1000000) : enc(300000));
            chk(last_acc == exp_c, "R3 random settle", last_acc, exp_c);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule